// File: doc/BRIEF.md
# Back-Pressured Receive FIFO for a Memory-Write DMA Path

This block receives a stream of bytes from a peripheral source through a valid/acknowledge handshake and holds them in a small on-chip FIFO. A DMA write port drains the FIFO toward memory whenever the memory side grants a slot. Each memory write carries an address taken from a simple incrementing pointer. Because the destination is main memory, one transfer may move far more bytes than the FIFO can hold.

The FIFO may back up when the memory side is slow. If throttling is enabled, the block raises a pause output once the fill level reaches a programmable almost-full threshold. A well-behaved source stops sending, and the margin left above the threshold absorbs any bytes that were already in flight. If throttling is disabled, or the source ignores the pause, a byte that arrives at a full FIFO is lost. A sticky overflow flag records this, and the transfer must then be retried.

Software starts a transfer by pulsing start along with a byte count and a base address. The block raises a one-cycle done pulse after the last byte of the count has been written to memory.

Top module: `rxf_dma_throttle`

## Requirements
- R1: After reset the FIFO is empty, no memory write is requested, the overflow flag is 0, the done pulse is 0, and the write address is 0.
- R2: A byte is acknowledged in the cycle it is offered (`i_src_valid`=1) whenever the FIFO holds fewer than DEPTH bytes. Accepted bytes leave the FIFO in arrival order.
- R3: A byte offered while the FIFO holds DEPTH bytes gets no acknowledge and is discarded, and the overflow flag becomes 1 from the next cycle. This holds even if a byte is drained in that same cycle.
- R4: The overflow flag stays 1 until a clear pulse with no new overflow in that cycle. A new overflow wins over a clear in the same cycle.
- R5: `o_src_pause` is 1 exactly when throttling is enabled and the fill level is at or above the threshold. It is combinational on the current fill level, and it is 0 whenever throttling is disabled.
- R6: A memory write is requested while a transfer is active and the FIFO is not empty. The write data is the oldest byte, and the write completes (the byte is popped) in a cycle where `i_mem_grant`=1.
- R7: A start pulse loads the write address from the base input, and each completed write increments the address by 1.
- R8: A transfer ends after exactly the programmed number of completed writes, and no further write is requested after that. `o_done` is 1 for the single cycle after the final write. A start with a count of 0 performs no write and pulses `o_done` in the next cycle.
- R9: A start pulse takes priority over a write that completes in the same cycle, for the address, the remaining count and the done pulse.
- R10: The transfer length is independent of DEPTH: a transfer longer than the FIFO completes as long as the source keeps supplying bytes.
- R11: Bytes are accepted while no transfer is active, and they wait in the FIFO for the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| i_src_valid | input | 1 | Source offers a byte |
| i_src_data | input | DW | Offered byte |
| o_src_ack | output | 1 | Byte accepted this cycle |
| o_src_pause | output | 1 | Slow-down request to the source |
| i_throttle_en | input | 1 | Enable back-pressure |
| i_afull_level | input | CW | Almost-full threshold in bytes |
| i_ovf_clear | input | 1 | Clear the sticky overflow flag |
| o_overflow | output | 1 | Sticky overflow flag |
| i_start | input | 1 | Begin a transfer |
| i_xfer_len | input | LW | Bytes to move in the transfer |
| i_base_addr | input | AW | First memory address |
| o_mem_wr_valid | output | 1 | Memory write requested |
| o_mem_wr_addr | output | AW | Memory write address |
| o_mem_wr_data | output | DW | Memory write data |
| i_mem_grant | input | 1 | Memory slot available this cycle |
| o_done | output | 1 | One-cycle transfer-complete pulse |

## Verification
A corrupted fill count is visible at the ports at once: both the acknowledge at the full boundary and the pause at the threshold depend on it. A pointer error shows up as wrong write data on the next memory write, which lets the comparison isolate ordering faults byte by byte. A wrong remaining count or address register shows up in `o_mem_wr_addr` one cycle after a write, or as a done pulse that arrives in the wrong cycle. The reference model is compared every cycle, so each of these faults is caught within a cycle or two of the point where it appears.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   typedef enum logic [0:0] {XFER_IDLE = 1'b0, XFER_RUN = 1'b1} xfer_state_e;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
   parameter int DW    = 8,
   parameter int DEPTH = 64,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic [CW-1:0] level,
   output logic          full,
   output logic          empty
);
   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;

   assign full  = (level == CW'(DEPTH));
   assign empty = (level == '0);
   assign head  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   // R2: fill level moves by at most one byte per cycle
   p_level_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (level == $past(level)) || (level == $past(level) + 1'b1) ||
      (level + 1'b1 == $past(level)));
endmodule

// File: rtl/rxf_throttle.sv
module rxf_throttle #(
   parameter int DEPTH     = 64,
   parameter bit REG_PAUSE = 1'b0,
   localparam int CW       = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] level,
   input  logic [CW-1:0] afull_level,
   input  logic          throttle_en,
   input  logic          offer,
   input  logic          full,
   input  logic          ovf_clear,
   output logic          pause,
   output logic          overflow
);
   logic at_mark;
   assign at_mark = throttle_en && (level >= afull_level);

   generate
      if (REG_PAUSE) begin : g_pause_reg
         logic pause_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pause_q <= 1'b0;
            else        pause_q <= at_mark;
         end
         assign pause = pause_q;
      end else begin : g_pause_comb
         assign pause = at_mark;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              overflow <= 1'b0;
      else if (offer && full)  overflow <= 1'b1;
      else if (ovf_clear)      overflow <= 1'b0;
   end

   // R4: flag only falls on a clear request
   p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !ovf_clear) |=> overflow);
endmodule

// File: rtl/rxf_drain.sv
module rxf_drain
   import rxf_pkg::*;
#(
   parameter int AW = 32,
   parameter int LW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [LW-1:0] xfer_len,
   input  logic [AW-1:0] base_addr,
   input  logic          empty,
   input  logic          grant,
   output logic          wr_valid,
   output logic [AW-1:0] wr_addr,
   output logic          fire,
   output logic          done
);
   xfer_state_e   state;
   logic [LW-1:0] remaining;

   assign wr_valid = (state == XFER_RUN) && !empty;
   assign fire     = wr_valid && grant;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= XFER_IDLE;
         remaining <= '0;
         wr_addr   <= '0;
         done      <= 1'b0;
      end else if (start) begin
         remaining <= xfer_len;
         wr_addr   <= base_addr;
         state     <= (xfer_len != '0) ? XFER_RUN : XFER_IDLE;
         done      <= (xfer_len == '0);
      end else begin
         done <= 1'b0;
         if (fire) begin
            wr_addr   <= wr_addr + 1'b1;
            remaining <= remaining - 1'b1;
            if (remaining == LW'(1)) begin
               state <= XFER_IDLE;
               done  <= 1'b1;
            end
         end
      end
   end

   // R7: address steps by one after each completed write
   p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(fire) && !$past(start)) |-> (wr_addr == $past(wr_addr) + 1'b1));
   // R8: done is only seen once the transfer has stopped
   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (state == XFER_IDLE));
endmodule

// File: rtl/rxf_dma_throttle.sv
module rxf_dma_throttle #(
   parameter int DW        = 8,
   parameter int DEPTH     = 64,
   parameter int AW        = 32,
   parameter int LW        = 16,
   parameter bit REG_PAUSE = 1'b0,
   localparam int CW       = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          i_src_valid,
   input  logic [DW-1:0] i_src_data,
   output logic          o_src_ack,
   output logic          o_src_pause,
   input  logic          i_throttle_en,
   input  logic [CW-1:0] i_afull_level,
   input  logic          i_ovf_clear,
   output logic          o_overflow,
   input  logic          i_start,
   input  logic [LW-1:0] i_xfer_len,
   input  logic [AW-1:0] i_base_addr,
   output logic          o_mem_wr_valid,
   output logic [AW-1:0] o_mem_wr_addr,
   output logic [DW-1:0] o_mem_wr_data,
   input  logic          i_mem_grant,
   output logic          o_done
);
   initial begin : param_checks
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
         $fatal(1, "DEPTH must be a power of two >= 2");
      if (DW < 1 || AW < 1 || LW < 1)
         $fatal(1, "widths must be positive");
   end

   logic [CW-1:0] level;
   logic          full, empty, push, pop;

   assign push      = i_src_valid && !full;
   assign o_src_ack = push;

   rxf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .push(push), .push_data(i_src_data),
      .pop(pop), .head(o_mem_wr_data), .level(level), .full(full),
      .empty(empty));

   rxf_throttle #(.DEPTH(DEPTH), .REG_PAUSE(REG_PAUSE)) u_throttle (
      .clk(clk), .rst_n(rst_n), .level(level), .afull_level(i_afull_level),
      .throttle_en(i_throttle_en), .offer(i_src_valid), .full(full),
      .ovf_clear(i_ovf_clear), .pause(o_src_pause), .overflow(o_overflow));

   rxf_drain #(.AW(AW), .LW(LW)) u_drain (
      .clk(clk), .rst_n(rst_n), .start(i_start), .xfer_len(i_xfer_len),
      .base_addr(i_base_addr), .empty(empty), .grant(i_mem_grant),
      .wr_valid(o_mem_wr_valid), .wr_addr(o_mem_wr_addr), .fire(pop),
      .done(o_done));

   // R3: a refused byte always leaves the overflow flag set
   p_refused_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (i_src_valid && !o_src_ack) |=> o_overflow);

   generate
      if (!REG_PAUSE) begin : g_pause_chk
         // R5: a full FIFO with throttling on always pauses the source
         p_pause_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (i_throttle_en && full && (i_afull_level <= CW'(DEPTH))) |-> o_src_pause);
      end
   endgenerate
endmodule

// File: tb/test_rxf_dma_throttle.sv
`timescale 1ns/1ps
module test_rxf_dma_throttle;
   localparam int DEPTH = 64;
   localparam int CW = $clog2(DEPTH + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic src_valid = 0, src_ack, src_pause, thr_en = 0, ovf_clr = 0, ovf;
   logic [7:0] src_data = 0, wr_data;
   logic [CW-1:0] afull = CW'(8);
   logic start = 0, wr_valid, grant = 0, done;
   logic [15:0] xlen = 0;
   logic [31:0] base = 0, wr_addr;

   int total = 0, bad = 0;
   bit finished = 0;

   // reference model state
   int q[$];
   bit m_ovf = 0, m_active = 0, m_done = 0;
   int m_rem = 0;
   logic [31:0] m_addr = 0;

   always #5 clk = ~clk;

   rxf_dma_throttle i_rxf_dma_throttle (
      .clk(clk), .rst_n(rst_n), .i_src_valid(src_valid), .i_src_data(src_data),
      .o_src_ack(src_ack), .o_src_pause(src_pause), .i_throttle_en(thr_en),
      .i_afull_level(afull), .i_ovf_clear(ovf_clr), .o_overflow(ovf),
      .i_start(start), .i_xfer_len(xlen), .i_base_addr(base),
      .o_mem_wr_valid(wr_valid), .o_mem_wr_addr(wr_addr), .o_mem_wr_data(wr_data),
      .i_mem_grant(grant), .o_done(done));

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      bit exp_valid;
      exp_valid = m_active && (q.size() > 0);
      check("R2 ack", src_ack, src_valid && (q.size() < DEPTH));
      check("R5 pause", src_pause, thr_en && (q.size() >= int'(afull)));
      check("R6 wr_valid", wr_valid, exp_valid);
      if (exp_valid) check("R6 wr_data", wr_data, q[0]);
      check("R7 wr_addr", wr_addr, m_addr);
      check("R3 overflow", ovf, m_ovf);
      check("R8 done", done, m_done);
   endtask

   task automatic model_edge();
      bit full, pop, nd;
      full = (q.size() == DEPTH);
      pop  = m_active && (q.size() > 0) && grant;
      if (src_valid && full) m_ovf = 1;
      else if (ovf_clr)      m_ovf = 0;
      nd = 0;
      if (start) begin
         m_rem = int'(xlen);
         m_addr = base;
         m_active = (xlen != 0);
         nd = (xlen == 0);
      end else if (pop) begin
         m_addr = m_addr + 1;
         if (m_rem == 1) begin m_active = 0; nd = 1; end
         m_rem--;
      end
      if (pop) void'(q.pop_front());
      if (src_valid && !full) q.push_back(int'(src_data));
      m_done = nd;
   endtask

   task automatic step(input logic v, input logic [7:0] d, input logic g);
      src_valid = v; src_data = d; grant = g;
      #1;
      compare_all();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      start = 0; ovf_clr = 0;
   endtask

   initial begin
      #(150000 * 10);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int seen_done;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 wr_valid", wr_valid, 0);
      check("R1 overflow", ovf, 0);
      check("R1 done", done, 0);
      check("R1 wr_addr", wr_addr, 0);
      rst_n = 1;
      @(negedge clk);

      // R11, R2, R3: fill with no transfer active, throttling off
      for (int k = 0; k < 70; k++) step(1, 8'(k * 7 + 3), 1);
      check("R3 overflow sticky", ovf, 1);
      // R4: overflow and clear in the same cycle, overflow wins
      ovf_clr = 1; step(1, 8'hEE, 0);
      check("R4 set wins", ovf, 1);
      ovf_clr = 1; step(0, 0, 0);
      check("R4 cleared", ovf, 0);

      // R3: full FIFO refuses even while draining in the same cycle
      xlen = 16'd3; base = 32'h1000; start = 1; step(0, 0, 0);
      step(1, 8'h55, 1);
      check("R3 refuse with pop", ovf, 1);
      step(0, 0, 1); step(0, 0, 1);
      ovf_clr = 1; step(0, 0, 0);

      // R9: start in the same cycle as a completed write
      xlen = 16'd4; base = 32'h2000; start = 1; step(0, 0, 0);
      step(0, 0, 1);
      xlen = 16'd2; base = 32'h3000; start = 1; step(0, 0, 1);
      check("R9 addr reload", wr_addr, 32'h3000);
      step(0, 0, 1); step(0, 0, 1); step(0, 0, 1);

      // R8: zero-length transfer
      xlen = 16'd0; base = 32'h4000; start = 1; step(0, 0, 1);
      check("R8 len0 done", done, 1);
      step(0, 0, 1);

      // R10, R5, R6: long transfer with throttling and a gappy grant
      thr_en = 1; afull = CW'(48);
      xlen = 16'd200; base = 32'h8000; start = 1; step(0, 0, 0);
      seen_done = 0;
      for (int k = 0; k < 1500; k++) begin
         if (done) seen_done++;
         step((k % 3 != 0) && !src_pause, 8'(k), (k % 5 > 1) || (k > 900));
      end
      check("R10 long transfer done once", seen_done, 1);
      check("R10 final addr", wr_addr, 32'h8000 + 200);

      // R5: threshold boundary with no drain
      afull = CW'(10);
      for (int k = 0; k < 14; k++) step(1, 8'(k + 100), 0);
      thr_en = 0; step(0, 0, 0);
      check("R5 pause off when disabled", src_pause, 0);
      xlen = 16'd20; base = 32'h0; start = 1; step(0, 0, 0);
      for (int k = 0; k < 30; k++) step(0, 0, 1);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule